// File: doc/BRIEF.md
# PHY Register Access Handshake Master

This block reads and writes 16-bit registers that live inside a PHY and cannot be reached through a memory map. The only path to them is a 20-bit control word, which the block drives, and a 17-bit status word, which the PHY returns. Every step of an access is a four-phase handshake. The block drives a control value and then polls the PHY's acknowledge until it reaches the expected level.

A host starts an access by pulsing `req` while `ready` is high. It supplies a direction, an address and, for a write, the data. The block first latches the address into the PHY. It then either strobes a read and captures the returned data, or captures the write data and strobes a write. When it has finished it returns the control word to zero and pulses `done`, with `err` reporting whether an acknowledge wait ran out of samples.

The acknowledge passes through a two-flop synchroniser before any comparison. Polling is spaced by a cycle counter. The default spacing is 200 cycles, which is 1 µs at 200 MHz.

Top module: `phy_reg_seq`

## Requirements
- R1: Out of reset `ready`=1, `done`=0, `err`=0 and `ctl`=0.
- R2: The control word is laid out as follows: bits 15:0 carry address or data, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is high at any time. Every access starts with the address alone on bits 15:0. Next, capture-address is raised with the address held, and the block waits for ack=1. Capture-address is then dropped with the address still held, and the block waits for ack=0.
- R3: A read proceeds in this order:
  - After address capture, the block drives only the read strobe, with bits 15:0 at zero, and waits for ack=1.
  - It then latches status bits 15:0 into `rdata`.
  - It drives the control word to zero and waits for ack=0.
- R4: A write proceeds in this order:
  - After address capture, the block drives the data alone.
  - It raises capture-data and waits for ack=1, then drops capture-data and waits for ack=0.
  - It drives only the write strobe and waits for ack=1, then returns to data only and waits for ack=0.
  - It clears the control word.
- R5: Status bit 16 is the acknowledge. Each wait samples the synchronised acknowledge at most POLL_LIMIT times, SAMPLE_GAP cycles apart. If the acknowledge never rises during address capture, `done` arrives 3+(POLL_LIMIT-1)*SAMPLE_GAP clock edges after the accepting edge.
- R6: When a wait fails, the access aborts. The control word is zero in the cycle before `done` and in the `done` cycle, and `err`=1 with `done`. `done` is a single-cycle pulse.
- R7: A `req` that arrives while `ready`=0 is ignored. It captures no address and writes no data.
- R8: `err` is cleared by the next access that completes normally, and it is reported with that access's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start an access; taken only while `ready` is high |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | PHY register address |
| wdata | input | 16 | Write data |
| ready | output | 1 | Idle and able to accept `req` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rdata | output | 16 | Read result, valid with `done` |
| ctl | output | 20 | Control word to the PHY |
| stat | input | 17 | Status word from the PHY: bit 16 is the acknowledge, bits 15:0 are read data |

## Verification
The assertions check the following on every cycle:
- at most one capture or strobe bit is high;
- a read strobe rises only straight after the address was held alone;
- a write strobe rises only after the data was held without capture-data;
- the control word is zero at `done`, and `done` lasts one cycle;
- latched address and data stay fixed while busy;
- the retry count stays below its limit.

Only the bench's scenarios can show the rest. Its PHY model detects ordering violations, and it stores writes and returns them on reads. The scenarios cover these behaviours:
- the data returned and stored across several addresses;
- the exact timeout latency when the acknowledge never rises;
- an abort when the acknowledge never falls;
- ignored requests made while busy;
- clearing of `err` on recovery.

// File: rtl/phy_reg_seq.sv
module phy_reg_seq #(
  parameter int POLL_LIMIT = 10,
  parameter int SAMPLE_GAP = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rd_nwr,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  output logic        ready,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic [19:0] ctl,
  input  logic [16:0] stat
);
  localparam int TW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(SAMPLE_GAP + 1);

  typedef enum logic [3:0] {
    IDLE, A_SET, A_CAP, A_REL, R_STB, R_CLR,
    W_SET, W_CAP, W_REL, W_STB, W_END, FIN
  } st_t;

  st_t st, nxt;
  logic [15:0] addr_q, wdata_q;
  logic        op_rd_q, fail_q, err_q, done_q;
  logic [15:0] rdata_q;
  logic [1:0]  ack_sync;
  logic [TW-1:0] tries;
  logic [GW-1:0] gap;
  logic waiting, want, ack_s;

  assign ack_s   = ack_sync[1];
  assign ready   = (st == IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;
  assign waiting = st inside {A_CAP, A_REL, R_STB, R_CLR, W_CAP, W_REL, W_STB, W_END};
  assign want    = st inside {A_CAP, R_STB, W_CAP, W_STB};

  always_comb begin
    case (st)
      A_SET, A_REL:         ctl = {4'b0000, addr_q};
      A_CAP:                ctl = {4'b0001, addr_q};
      R_STB:                ctl = {4'b1000, 16'h0000};
      W_SET, W_REL, W_END:  ctl = {4'b0000, wdata_q};
      W_CAP:                ctl = {4'b0010, wdata_q};
      W_STB:                ctl = {4'b0100, 16'h0000};
      default:              ctl = 20'h0;
    endcase
  end

  always_comb begin
    case (st)
      A_SET:   nxt = A_CAP;
      A_CAP:   nxt = A_REL;
      A_REL:   nxt = op_rd_q ? R_STB : W_SET;
      R_STB:   nxt = R_CLR;
      R_CLR:   nxt = FIN;
      W_SET:   nxt = W_CAP;
      W_CAP:   nxt = W_REL;
      W_REL:   nxt = W_STB;
      W_STB:   nxt = W_END;
      W_END:   nxt = FIN;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_sync <= 2'b00;
    else        ack_sync <= {ack_sync[0], stat[16]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      op_rd_q <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      tries   <= '0;
      gap     <= '0;
    end else begin
      done_q <= 1'b0;
      if (st == IDLE) begin
        if (req) begin
          addr_q  <= addr;
          wdata_q <= wdata;
          op_rd_q <= rd_nwr;
          fail_q  <= 1'b0;
          tries   <= '0;
          gap     <= '0;
          st      <= A_SET;
        end
      end else if (st == FIN) begin
        done_q <= 1'b1;
        err_q  <= fail_q;
        st     <= IDLE;
      end else if (!waiting) begin
        st <= nxt;
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end else if (ack_s == want) begin
        if (st == R_STB) rdata_q <= stat[15:0];
        tries <= '0;
        st    <= nxt;
      end else if (tries == TW'(POLL_LIMIT - 1)) begin
        tries  <= '0;
        fail_q <= 1'b1;
        st     <= FIN;
      end else begin
        tries <= tries + 1'b1;
        gap   <= GW'(SAMPLE_GAP - 1);
      end
    end
  end

  a_r2_one_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl[19:16]));
  a_r3_rd_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[19]) |-> $past(ctl[16:0]) == {1'b0, addr_q});
  a_r4_wr_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[18]) |-> ($past(ctl[15:0]) == wdata_q) && !$past(ctl[17]));
  a_r5_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries) < POLL_LIMIT);
  a_r6_done_ctl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctl == 20'h0);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(addr_q) && $stable(wdata_q));
endmodule

// File: tb/sim_phy_reg_seq.sv
`timescale 1ns/1ps
module sim_phy_reg_seq;
  localparam int LIM = 10;
  localparam int GAP = 5;

  logic clk = 0, rst_n = 0;
  logic req = 0, rd_nwr = 0;
  logic [15:0] addr = 0, wdata = 0;
  logic ready, done, err;
  logic [15:0] rdata;
  logic [19:0] ctl;
  logic [16:0] stat;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phy_reg_seq #(.POLL_LIMIT(LIM), .SAMPLE_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .addr(addr),
    .wdata(wdata), .ready(ready), .done(done), .err(err), .rdata(rdata),
    .ctl(ctl), .stat(stat));

  // PHY model: 0 normal, 1 ack stuck low, 2 ack never falls
  logic [1:0]  mode = 0;
  logic [3:0]  c_d1, c_d2, c_prev;
  logic        ack_raw, addr_ok;
  logic [15:0] m_addr, m_data, rd_val;
  logic [15:0] m_mem [16];
  int viol;

  assign stat = {ack_raw, rd_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_d1 <= 0; c_d2 <= 0; c_prev <= 0; ack_raw <= 0; addr_ok <= 0;
      m_addr <= 0; m_data <= 0; rd_val <= 0; viol <= 0;
      for (int i = 0; i < 16; i++) m_mem[i] <= 16'h0;
    end else begin
      c_d1 <= ctl[19:16];
      c_d2 <= c_d1;
      c_prev <= ctl[19:16];
      if (mode == 1)      ack_raw <= 1'b0;
      else if (mode == 2) ack_raw <= ack_raw | (|c_d2);
      else                ack_raw <= |c_d2;
      if ((ctl[19:16] & ~c_prev) != 4'b0 && ack_raw) viol <= viol + 1;
      if (ctl[16] && !c_prev[0]) begin m_addr <= ctl[15:0]; addr_ok <= 1; end
      if (ctl[17] && !c_prev[1]) begin
        if (!addr_ok) viol <= viol + 1;
        m_data <= ctl[15:0];
      end
      if (ctl[18] && !c_prev[2]) begin
        if (!addr_ok) viol <= viol + 1;
        m_mem[m_addr[3:0]] <= m_data;
        addr_ok <= 0;
      end
      if (ctl[19] && !c_prev[3]) begin
        if (!addr_ok || ctl[15:0] != 0) viol <= viol + 1;
        rd_val <= m_mem[m_addr[3:0]];
        addr_ok <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic [15:0] a, input logic [15:0] d,
                        input bit spam, output int n, output logic e, output logic [15:0] q);
    @(negedge clk);
    req = 1; rd_nwr = r; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; n = 0;
    while (1) begin
      @(posedge clk); n++; #1;
      if (done) break;
      if (spam && (n == 6 || n == 20)) begin
        chk(ready == 0, "R7 busy while spamming", ready, 0);
        req = 1; rd_nwr = 0; addr = 16'h1007; wdata = 16'h1111;
      end else req = 0;
      if (n > 3000) break;
    end
    req = 0;
    e = err; q = rdata;
    chk(ctl == 0, "R6 ctl zero at done", ctl, 0);
    @(posedge clk); #1;
    chk(done == 0, "R6 done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk(ready == 1, "R1 ready", ready, 1);
    chk(done == 0, "R1 done", done, 0);
    chk(err == 0, "R1 err", err, 0);
    chk(ctl == 0, "R1 ctl", ctl, 0);
  endtask

  task automatic t_write_read(input logic [15:0] a, input logic [15:0] d);
    int n; logic e; logic [15:0] q;
    access(0, a, d, 0, n, e, q);
    chk(e == 0, "R4 write err", e, 0);
    chk(m_mem[a[3:0]] == d, "R4 write stored", m_mem[a[3:0]], d);
    access(1, a, 16'hFFFF, 0, n, e, q);
    chk(e == 0, "R3 read err", e, 0);
    chk(q == d, "R3 read data", q, d);
    chk(viol == 0, "R2 handshake order", viol, 0);
  endtask

  task automatic t_busy_ignore();
    int n; logic e; logic [15:0] q;
    access(0, 16'h1003, 16'hA5A5, 1, n, e, q);
    chk(m_mem[3] == 16'hA5A5, "R7 original write", m_mem[3], 16'hA5A5);
    access(1, 16'h1007, 16'h0, 0, n, e, q);
    chk(q == 16'h0, "R7 spammed write ignored", q, 0);
  endtask

  task automatic t_timeout_rise();
    int n; logic e; logic [15:0] q;
    mode = 1;
    access(0, 16'h100A, 16'h7777, 0, n, e, q);
    chk(n == 3 + (LIM-1)*GAP, "R5 timeout latency", n, 3 + (LIM-1)*GAP);
    chk(e == 1, "R6 err on ack never high", e, 1);
    chk(m_mem[10] == 0, "R6 no write on abort", m_mem[10], 0);
    mode = 0;
  endtask

  task automatic t_timeout_fall_recover();
    int n; logic e; logic [15:0] q;
    mode = 2;
    access(0, 16'h1009, 16'hBEEF, 0, n, e, q);
    chk(e == 1, "R6 err on ack never low", e, 1);
    chk(m_mem[9] == 0, "R6 no write when stuck", m_mem[9], 0);
    mode = 0;
    repeat (10) @(posedge clk);
    #1;
    access(1, 16'h1005, 16'h0, 0, n, e, q);
    chk(e == 0, "R8 err cleared", e, 0);
    chk(q == 16'h5A01, "R8 read after recovery", q, 16'h5A01);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_write_read(16'h1005, 16'h5A01);
    t_write_read(16'h100D, 16'hFFFF);
    t_write_read(16'h2002, 16'h0000);
    t_write_read(16'h300E, 16'h8001);
    t_busy_ignore();
    t_timeout_rise();
    t_timeout_fall_recover();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule